// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave on a two-wire serial bus with a clock line and an open-drain data line. It gives a bus host read and write access to a bank of 128 registers, each 8 bits wide. The clock and data inputs are synchronised into the system clock domain and edge-detected there. The slave finds start and stop conditions and answers only to its own 7-bit device ID. It drives the data line solely through an active-high pull-down enable.

After the device ID and a write direction bit, the host sends a register address byte. Bit 7 of that byte picks the addressing mode and bits 6:0 load the internal address pointer. With bit 7 clear, the slave expects bytes that alternate between address and data until the next stop. With bit 7 set, data bytes go to successive registers. A read that follows a repeated start shifts out the register the pointer selects, most significant bit first. The host ends a read by returning a not-acknowledge.

Top module: `regbus_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and every register reads back as 0x00.
- R2: A start condition followed by the device ID (default 7'h3A) and a 0 direction bit is acknowledged: the slave holds the line low for the whole high phase of the ninth clock.
- R3: If the device ID does not match, the slave gives no acknowledge, keeps the line released, and writes nothing until the next start or stop condition.
- R4: In a write, the byte after the device ID is a register address byte. Bit 7 is the auto-increment flag and bits 6:0 load the address pointer. The byte is acknowledged.
- R5: With the flag at 0, data and address bytes alternate: every data byte is written to the address sent just before it, and the byte after each data byte is taken as a new address.
- R6: With the flag at 1, each data byte in a write goes to the next register, and the pointer wraps from 127 to 0.
- R7: After the device ID with direction bit 1, the slave shifts out the addressed register MSB first. A host acknowledge makes it send another byte. A not-acknowledge makes it release the line until the next start or stop.
- R8: During reads the pointer steps by one per byte when the flag is 1. When the flag is 0, the same register is sent again.
- R9: A stop condition or a repeated start aborts any byte in progress, and the next byte is taken as a device ID.
- R10: `sda_oe` changes only while the synchronised clock is low, or when a start or stop condition releases it, so the line never moves during a clock high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired-AND level) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions assume that the host changes the data line only while the clock is low, except when it deliberately makes a start or stop condition. They also assume that each bus clock phase lasts several system clocks, so that every synchroniser edge stands apart from the others. The stimulus holds every clock phase for ten system clocks and changes data only in the low phase. Start, stop and repeated start conditions are built with a full phase on each side of the data transition.

// File: rtl/regbus_slave.sv
module regbus_slave #(
  parameter logic [6:0] DEV_ID = 7'h3A,
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] S_IDLE = 3'd0, S_DEV = 3'd1, S_RAB = 3'd2,
                         S_WR = 3'd3, S_RD = 3'd4, S_IGN = 3'd5;

  logic [2:0] scl_s, sda_s;
  logic [2:0] state;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic [DW-1:0] tx;
  logic [AW-1:0] ptr;
  logic rw, ainc, mack;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  wire sda      = sda_s[1];
  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire start_ev = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire stop_ev  = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];
  wire match    = (sr[7:1] == DEV_ID);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sr     <= '0;
      tx     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      ainc   <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (start_ev) begin
      state  <= S_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (scl_rise && state != S_IDLE) begin
      if (cnt < 4'd8) begin
        sr  <= {sr[6:0], sda};
        cnt <= cnt + 4'd1;
      end else if (cnt == 4'd8) begin
        mack <= ~sda;
        cnt  <= 4'd9;
      end
    end else if (scl_fall && state != S_IDLE) begin
      if (cnt == 4'd8) begin
        case (state)
          S_DEV: if (match) begin
                   sda_oe <= 1'b1;
                   rw     <= sr[0];
                 end else state <= S_IGN;
          S_RAB: begin
                   sda_oe <= 1'b1;
                   ainc   <= sr[7];
                   ptr    <= sr[AW-1:0];
                 end
          S_WR:  begin
                   sda_oe   <= 1'b1;
                   mem[ptr] <= sr[DW-1:0];
                   if (ainc) ptr <= ptr + 1'b1;
                 end
          S_RD:  begin
                   sda_oe <= 1'b0;
                   if (ainc) ptr <= ptr + 1'b1;
                 end
          default: ;
        endcase
      end else if (cnt == 4'd9) begin
        cnt    <= '0;
        sda_oe <= 1'b0;
        case (state)
          S_DEV: if (rw) begin
                   state  <= S_RD;
                   tx     <= mem[ptr];
                   sda_oe <= ~mem[ptr][DW-1];
                 end else state <= S_RAB;
          S_RAB: state <= S_WR;
          S_WR:  state <= ainc ? S_WR : S_RAB;
          S_RD:  if (mack) begin
                   tx     <= mem[ptr];
                   sda_oe <= ~mem[ptr][DW-1];
                 end else state <= S_IGN;
          default: ;
        endcase
      end else if (state == S_RD && cnt != 4'd0) begin
        sda_oe <= ~tx[3'd7 - cnt[2:0]];
      end
    end
endmodule

// File: rtl/regbus_slave_chk.sv
module regbus_slave_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_d,
  input logic          start_ev,
  input logic          stop_ev,
  input logic [2:0]    state,
  input logic [3:0]    cnt,
  input logic [AW-1:0] ptr
);
  assert_oe_set_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_d));

  assert_oe_release_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!$past(scl_d) || $past(start_ev) || $past(stop_ev)));

  assert_stop_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_oe && state == 3'd0));

  assert_start_expects_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == 3'd1 && cnt == 4'd0));

  assert_ignore_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5) |-> !sda_oe);

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> (ptr == AW'($past(ptr) + 1'b1) || $past(state) == 3'd2));
endmodule

bind regbus_slave regbus_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_d(scl_s[1]),
  .start_ev(start_ev), .stop_ev(stop_ev), .state(state), .cnt(cnt), .ptr(ptr)
);

// File: tb/sim_regbus_slave.sv
module sim_regbus_slave;
  localparam int H = 10;
  localparam logic [6:0] ID = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic oe;
  wire  sda_line = sda_m & ~oe;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] rbuf [4];

  always #4 clk = ~clk;

  regbus_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(oe));

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    logic a0, a1;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(2); a0 = ~sda_line; wt(H - 4);
    a1 = ~sda_line; wt(2); scl_m = 1'b0;
    ack = a0 & a1;
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] b, output logic stable);
    logic a, c;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(2); a = sda_line; wt(H - 4);
      c = sda_line; wt(2); scl_m = 1'b0;
      b[i] = a;
      if (a != c) stable = 1'b0;
    end
    wbit(~give_ack);
    sda_m = 1'b1;
  endtask

  task automatic read_seq(input logic [7:0] rab, input int n, input string tag);
    logic ack, st;
    bus_start;
    send({ID, 1'b0}, ack); chk(ack, {tag, " id ack R2"}, 8'(ack), 8'h01);
    send(rab, ack);        chk(ack, {tag, " rab ack R4"}, 8'(ack), 8'h01);
    bus_start;
    send({ID, 1'b1}, ack); chk(ack, {tag, " read id ack R7"}, 8'(ack), 8'h01);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, rbuf[i], st);
      chk(st, {tag, " line stable in high R10"}, 8'(st), 8'h01);
    end
    wt(H);
    chk(oe == 1'b0, {tag, " released after nack R7"}, 8'(oe), 8'h00);
    bus_stop;
  endtask

  task automatic t_reset;
    chk(oe == 1'b0, "reset oe R1", 8'(oe), 8'h00);
    read_seq(8'h05, 1, "reset");
    chk(rbuf[0] == 8'h00, "reset reg R1", rbuf[0], 8'h00);
  endtask

  task automatic t_alt_write;
    logic ack;
    bus_start;
    send({ID, 1'b0}, ack); chk(ack, "alt id R2", 8'(ack), 8'h01);
    send(8'h10, ack);      chk(ack, "alt rab R4", 8'(ack), 8'h01);
    send(8'hA5, ack);      chk(ack, "alt data R5", 8'(ack), 8'h01);
    send(8'h20, ack);      chk(ack, "alt rab2 R5", 8'(ack), 8'h01);
    send(8'h5A, ack);      chk(ack, "alt data2 R5", 8'(ack), 8'h01);
    bus_stop;
    read_seq(8'h10, 1, "alt"); chk(rbuf[0] == 8'hA5, "alt reg10 R5", rbuf[0], 8'hA5);
    read_seq(8'h20, 1, "alt"); chk(rbuf[0] == 8'h5A, "alt reg20 R5", rbuf[0], 8'h5A);
    read_seq(8'h11, 1, "alt"); chk(rbuf[0] == 8'h00, "alt reg11 untouched R5", rbuf[0], 8'h00);
  endtask

  task automatic t_autoinc;
    logic ack;
    bus_start;
    send({ID, 1'b0}, ack);
    send(8'hFE, ack); chk(ack, "ainc rab R4", 8'(ack), 8'h01);
    send(8'h11, ack); send(8'h22, ack); send(8'h33, ack);
    chk(ack, "ainc data ack R6", 8'(ack), 8'h01);
    bus_stop;
    read_seq(8'hFE, 3, "ainc");
    chk(rbuf[0] == 8'h11, "ainc reg7E R6", rbuf[0], 8'h11);
    chk(rbuf[1] == 8'h22, "ainc reg7F R8", rbuf[1], 8'h22);
    chk(rbuf[2] == 8'h33, "ainc wrap reg00 R6", rbuf[2], 8'h33);
    read_seq(8'h00, 1, "wrap");
    chk(rbuf[0] == 8'h33, "wrap direct R6", rbuf[0], 8'h33);
  endtask

  task automatic t_alt_read;
    read_seq(8'h10, 2, "altrd");
    chk(rbuf[0] == 8'hA5, "altrd first R7", rbuf[0], 8'hA5);
    chk(rbuf[1] == 8'hA5, "altrd same reg R8", rbuf[1], 8'hA5);
  endtask

  task automatic t_mismatch;
    logic ack;
    bus_start;
    send({7'h3B, 1'b0}, ack); chk(!ack, "bad id nack R3", 8'(ack), 8'h00);
    send(8'h30, ack);         chk(!ack, "ignored rab R3", 8'(ack), 8'h00);
    send(8'h77, ack);         chk(!ack, "ignored data R3", 8'(ack), 8'h00);
    bus_stop;
    read_seq(8'h30, 1, "bad");
    chk(rbuf[0] == 8'h00, "no write on bad id R3", rbuf[0], 8'h00);
  endtask

  task automatic t_restart;
    logic ack;
    bus_start;
    send({ID, 1'b0}, ack);
    send(8'h40, ack);
    bus_start;
    send({ID, 1'b0}, ack); chk(ack, "restart id R9", 8'(ack), 8'h01);
    send(8'h41, ack);
    send(8'h99, ack);
    bus_stop;
    read_seq(8'h41, 1, "rs"); chk(rbuf[0] == 8'h99, "restart write R9", rbuf[0], 8'h99);
    read_seq(8'h40, 1, "rs"); chk(rbuf[0] == 8'h00, "restart no stray R9", rbuf[0], 8'h00);
    bus_start;
    for (int i = 0; i < 4; i++) wbit(ID[6 - i]);
    bus_stop;
    bus_start;
    send({ID, 1'b0}, ack); chk(ack, "after aborted byte R9", 8'(ack), 8'h01);
    send(8'h50, ack);
    send(8'h3C, ack);
    bus_stop;
    read_seq(8'h50, 1, "ab"); chk(rbuf[0] == 8'h3C, "write after abort R9", rbuf[0], 8'h3C);
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset;
    t_alt_write;
    t_autoinc;
    t_alt_read;
    t_mismatch;
    t_restart;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog timeout actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule